// File: doc/BRIEF.md
# Serial Port Power-Down Quiesce Sequencer

This block walks a synchronous serial port into a clean idle condition before a power controller is allowed to gate it. After a start strobe it first holds every reset of the port and shuts off the DMA channels that feed it. It then forces all clock and frame sources to internal and lets the transmitter, the receiver and the rate generator out of reset. The frame generator stays in reset.

Once two rate-generator ticks have passed, the block writes a first dummy transmit word. It waits for at least one bit-clock tick and for transmit-ready to come back, then writes a second dummy word. If a receive word is pending, it reads that word once and drops it. Only then does it raise a power-down request.

A wake strobe ends the request. The block then puts back the clock and frame configuration it saved at start and pulses done. If an expected tick or flag never arrives, a cycle timeout ends the sequence early with an error flag, and no power-down request is made.

Top module: `sport_quiesce_seq`

## Requirements
- R1: One cycle after a start strobe seen in idle, busy_o is 1, dma_dis_o is 1, and rst_ctl_o is 4'b1111. The bits of rst_ctl_o are bit0 transmitter, bit1 receiver, bit2 frame generator and bit3 rate generator, and 1 means held in reset. cfg_o still shows the configuration presented at start.
- R2: In the cycle after that, cfg_o equals 7'h3F while rst_ctl_o stays 4'b1111. The cfg_o bits are bit0 rate clock internal, bit1 rate frame internal, bit2 transmit clock internal, bit3 receive clock internal, bit4 transmit frame internal, bit5 receive frame internal and bit6 external clock select.
- R3: In the following cycle rst_ctl_o becomes 4'b0100, so only the frame generator is held. It keeps that value through both writes and the power-down request.
- R4: The first dummy write comes only after two srg_tick_i pulses have been seen following the release.
- R5: Each dummy write is a one-cycle tx_wr_o pulse with tx_data_o equal to the DUMMY_WORD parameter.
- R6: The second write comes only after at least one bit_tick_i pulse following the first write, with xmit_rdy_i high. The two write pulses are never in adjacent cycles.
- R7: After the second write, exactly one rx_rd_o pulse is issued if recv_rdy_i is high. If recv_rdy_i is low, no read is issued.
- R8: pdn_req_o rises only after both writes and the drain step. It stays high until wake_i.
- R9: One cycle after wake_i is seen during the request, done_o pulses for one cycle. In that cycle pdn_req_o, busy_o, dma_dis_o and rst_ctl_o are 0, and cfg_o equals the configuration captured at start.
- R10: If either wait lasts TMO_CYC cycles without completing, the sequence ends with done_o and err_o = 1 and without pdn_req_o. err_o stays 1 until the next start, which clears it.
- R11: A start strobe received while busy is ignored. The sequence continues and does not go back to holding all resets.
- R12: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin the quiesce sequence |
| wake_i | input | 1 | Power controller has woken the port |
| xmit_rdy_i | input | 1 | Port transmit-ready flag |
| recv_rdy_i | input | 1 | Port receive-ready flag |
| srg_tick_i | input | 1 | One pulse per rate-generator clock |
| bit_tick_i | input | 1 | One pulse per bit clock |
| cfg_in_i | input | 7 | Current clock and frame configuration of the port |
| rst_ctl_o | output | 4 | Reset holds toward the port |
| cfg_o | output | 7 | Clock and frame configuration driven to the port |
| dma_dis_o | output | 1 | Disable DMA channels serving the port |
| tx_wr_o | output | 1 | Transmit data register write strobe |
| tx_data_o | output | DATA_W | Dummy word written |
| rx_rd_o | output | 1 | Receive data register read strobe |
| pdn_req_o | output | 1 | Power-down request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished (one cycle) |
| err_o | output | 1 | Last sequence ended by timeout |

## Verification
All outputs are registered from the next state. The reset holds and busy appear one cycle after the start edge, the quiesce configuration after two, and the partial release after three. A write comes one cycle after the edge that completes its wait condition, and done comes one cycle after the wake edge. The bench drives inputs and samples outputs at the falling edge, so each exact-cycle check reads the value of the cycle that just started. The ordering of writes, reads, requests and done is checked through an expected-event queue that a monitor consumes as each event appears. Tick counts are recorded at the moment of each write.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int CFG_W = 7;
  localparam int RST_W = 4;
  localparam logic [CFG_W-1:0] CFG_QUIESCE = 7'h3F;
  localparam logic [RST_W-1:0] RST_ALL = 4'b1111;
  localparam logic [RST_W-1:0] RST_FRAME_ONLY = 4'b0100;

  typedef enum logic [3:0] {
    S_IDLE, S_HOLD, S_CFG, S_REL, S_SYNC, S_WR1,
    S_BITW, S_WR2, S_DRAIN, S_RD, S_PDN, S_DONE
  } sq_state_e;
endpackage

// File: rtl/sq_wait_timer.sv
module sq_wait_timer #(
  parameter int TICK_W = 2,
  parameter int CYC_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              tick,
  output logic [TICK_W-1:0] ticks,
  output logic [CYC_W-1:0]  cycles
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ticks  <= '0;
      cycles <= '0;
    end else begin
      if (tick && ticks != '1) ticks <= ticks + 1'b1;
      if (cycles != '1) cycles <= cycles + 1'b1;
    end
  end
endmodule

// File: rtl/sq_cfg_shadow.sv
module sq_cfg_shadow #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)      q[i] <= 1'b0;
      else if (cap) q[i] <= d[i];
    end
  end
endmodule

// File: rtl/sport_quiesce_seq.sv
module sport_quiesce_seq
  import sq_pkg::*;
#(
  parameter int              DATA_W     = 16,
  parameter logic [DATA_W-1:0] DUMMY_WORD = 16'hA5A5,
  parameter int              SYNC_TICKS = 2,
  parameter int              BIT_TICKS  = 1,
  parameter int              TMO_CYC    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              wake_i,
  input  logic              xmit_rdy_i,
  input  logic              recv_rdy_i,
  input  logic              srg_tick_i,
  input  logic              bit_tick_i,
  input  logic [CFG_W-1:0]  cfg_in_i,
  output logic [RST_W-1:0]  rst_ctl_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              dma_dis_o,
  output logic              tx_wr_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              rx_rd_o,
  output logic              pdn_req_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o
);
  localparam int MAX_TICKS = (SYNC_TICKS > BIT_TICKS) ? SYNC_TICKS : BIT_TICKS;
  localparam int TICK_W    = $clog2(MAX_TICKS + 1) + 1;
  localparam int CYC_W     = $clog2(TMO_CYC + 1);
  localparam logic [TICK_W-1:0] SYNC_N   = TICK_W'(SYNC_TICKS);
  localparam logic [TICK_W-1:0] BIT_N    = TICK_W'(BIT_TICKS);
  localparam logic [CYC_W-1:0]  TMO_LAST = CYC_W'(TMO_CYC - 1);

  sq_state_e           st_q, st_d;
  logic                tmo_hit;
  logic                tmr_clr, tmr_tick;
  logic [TICK_W-1:0]   tk_cnt;
  logic [CYC_W-1:0]    cyc_cnt;
  logic [CFG_W-1:0]    saved_cfg;
  logic                cap_cfg;

  assign cap_cfg  = (st_q == S_IDLE) && start_i;
  assign tmr_clr  = (st_d != st_q);
  assign tmr_tick = (st_q == S_SYNC) ? srg_tick_i : bit_tick_i;

  sq_wait_timer #(.TICK_W(TICK_W), .CYC_W(CYC_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clr    (tmr_clr),
    .tick   (tmr_tick),
    .ticks  (tk_cnt),
    .cycles (cyc_cnt)
  );

  sq_cfg_shadow #(.W(CFG_W)) u_shadow (
    .clk (clk),
    .rst (rst),
    .cap (cap_cfg),
    .d   (cfg_in_i),
    .q   (saved_cfg)
  );

  always_comb begin
    st_d    = st_q;
    tmo_hit = 1'b0;
    unique case (st_q)
      S_IDLE:  if (start_i) st_d = S_HOLD;
      S_HOLD:  st_d = S_CFG;
      S_CFG:   st_d = S_REL;
      S_REL:   st_d = S_SYNC;
      S_SYNC: begin
        if (tk_cnt >= SYNC_N) st_d = S_WR1;
        else if (cyc_cnt == TMO_LAST) begin
          st_d    = S_DONE;
          tmo_hit = 1'b1;
        end
      end
      S_WR1:   st_d = S_BITW;
      S_BITW: begin
        if (tk_cnt >= BIT_N && xmit_rdy_i) st_d = S_WR2;
        else if (cyc_cnt == TMO_LAST) begin
          st_d    = S_DONE;
          tmo_hit = 1'b1;
        end
      end
      S_WR2:   st_d = S_DRAIN;
      S_DRAIN: st_d = recv_rdy_i ? S_RD : S_PDN;
      S_RD:    st_d = S_PDN;
      S_PDN:   if (wake_i) st_d = S_DONE;
      S_DONE:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  logic nxt_wr;
  assign nxt_wr = (st_d == S_WR1) || (st_d == S_WR2);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      rst_ctl_o <= '0;
      cfg_o     <= '0;
      dma_dis_o <= 1'b0;
      tx_wr_o   <= 1'b0;
      tx_data_o <= '0;
      rx_rd_o   <= 1'b0;
      pdn_req_o <= 1'b0;
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_d == S_HOLD || st_d == S_CFG)
        rst_ctl_o <= RST_ALL;
      else if (st_d inside {S_REL, S_SYNC, S_WR1, S_BITW, S_WR2, S_DRAIN, S_RD, S_PDN})
        rst_ctl_o <= RST_FRAME_ONLY;
      else
        rst_ctl_o <= '0;
      unique case (st_d)
        S_IDLE, S_HOLD: cfg_o <= cfg_in_i;
        S_DONE:         cfg_o <= saved_cfg;
        default:        cfg_o <= CFG_QUIESCE;
      endcase
      dma_dis_o <= !(st_d inside {S_IDLE, S_DONE});
      busy_o    <= !(st_d inside {S_IDLE, S_DONE});
      tx_wr_o   <= nxt_wr;
      tx_data_o <= nxt_wr ? DUMMY_WORD : '0;
      rx_rd_o   <= (st_d == S_RD);
      pdn_req_o <= (st_d == S_PDN);
      done_o    <= (st_d == S_DONE);
      if (cap_cfg)      err_o <= 1'b0;
      else if (tmo_hit) err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sport_quiesce_seq_chk.sv
module sport_quiesce_seq_chk
  import sq_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             recv_rdy_i,
  input logic [RST_W-1:0] rst_ctl_o,
  input logic [CFG_W-1:0] cfg_o,
  input logic             dma_dis_o,
  input logic             tx_wr_o,
  input logic             rx_rd_o,
  input logic             pdn_req_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o
);
  AST_BUSY_ENTRY_HOLDS_ALL: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (rst_ctl_o == RST_ALL) && dma_dis_o); // R1
  AST_WR_FRAME_ONLY: assert property (@(posedge clk) disable iff (rst)
    tx_wr_o |-> (rst_ctl_o == RST_FRAME_ONLY) && (cfg_o == CFG_QUIESCE)); // R3
  AST_WR_NOT_ADJACENT: assert property (@(posedge clk) disable iff (rst)
    tx_wr_o |=> !tx_wr_o); // R6
  AST_RD_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
    rx_rd_o |-> $past(recv_rdy_i)); // R7
  AST_PDN_QUIESCED: assert property (@(posedge clk) disable iff (rst)
    pdn_req_o |-> dma_dis_o && busy_o && (rst_ctl_o == RST_FRAME_ONLY) && !tx_wr_o && !rx_rd_o); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o && !pdn_req_o && !dma_dis_o); // R9
  AST_ERR_NO_PDN: assert property (@(posedge clk) disable iff (rst)
    err_o |-> !pdn_req_o); // R10
  AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> busy_o || done_o); // R11
  AST_RESTART_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && rst_ctl_o == RST_FRAME_ONLY) |=> (rst_ctl_o != RST_ALL)); // R11
endmodule

bind sport_quiesce_seq sport_quiesce_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .recv_rdy_i (recv_rdy_i),
  .rst_ctl_o  (rst_ctl_o),
  .cfg_o      (cfg_o),
  .dma_dis_o  (dma_dis_o),
  .tx_wr_o    (tx_wr_o),
  .rx_rd_o    (rx_rd_o),
  .pdn_req_o  (pdn_req_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o)
);

// File: tb/sport_quiesce_seq_test.sv
module sport_quiesce_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] DUMMY = 16'hA5A5;
  localparam int EV_BUSY = 1, EV_WR = 2, EV_RD = 3, EV_PDN = 4, EV_DONE = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, wake_i = 0, xmit_rdy_i = 1, recv_rdy_i = 0;
  logic srg_tick_i = 0, bit_tick_i = 0;
  logic [6:0] cfg_in_i = '0;
  logic [3:0] rst_ctl_o;
  logic [6:0] cfg_o;
  logic dma_dis_o, tx_wr_o, rx_rd_o, pdn_req_o, busy_o, done_o, err_o;
  logic [15:0] tx_data_o;

  int total = 0, bad = 0;
  int srg_sent = 0, bit_sent = 0, wr_idx = 0;
  int exp_q[$];
  logic prev_busy = 0, prev_pdn = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sport_quiesce_seq uut (
    .clk(clk), .rst(rst), .start_i(start_i), .wake_i(wake_i),
    .xmit_rdy_i(xmit_rdy_i), .recv_rdy_i(recv_rdy_i),
    .srg_tick_i(srg_tick_i), .bit_tick_i(bit_tick_i), .cfg_in_i(cfg_in_i),
    .rst_ctl_o(rst_ctl_o), .cfg_o(cfg_o), .dma_dis_o(dma_dis_o),
    .tx_wr_o(tx_wr_o), .tx_data_o(tx_data_o), .rx_rd_o(rx_rd_o),
    .pdn_req_o(pdn_req_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic pop_event(input int ev, input string req);
    if (exp_q.size() == 0) chk(req, ev, 0);
    else chk(req, ev, exp_q.pop_front());
  endtask

  // monitor: consumes expected events as the outputs show them
  always @(negedge clk) begin
    if (!rst) begin
      if (busy_o && !prev_busy) pop_event(EV_BUSY, "R1 event");
      if (tx_wr_o) begin
        pop_event(EV_WR, "R5 event");
        chk("R5 data", tx_data_o, DUMMY);
        if (wr_idx == 0) chk("R4 srg ticks before write1", srg_sent, 2);
        else chk("R6 bit tick before write2", (bit_sent >= 1), 1);
        wr_idx++;
      end
      if (rx_rd_o) pop_event(EV_RD, "R7 event");
      if (pdn_req_o && !prev_pdn) pop_event(EV_PDN, "R8 event");
      if (done_o) pop_event(EV_DONE, "R9 event");
    end
    prev_busy = busy_o;
    prev_pdn  = pdn_req_o;
  end

  task automatic wait_for(input int which);
    do @(negedge clk);
    while (!((which == 0 && tx_wr_o) || (which == 1 && pdn_req_o) || (which == 2 && done_o)));
  endtask

  task automatic send_srg_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (2) @(negedge clk);
      srg_tick_i = 1; srg_sent++;
      @(negedge clk);
      srg_tick_i = 0;
    end
  endtask

  // start, then check the three fixed-latency steps
  task automatic begin_seq(input logic [6:0] cfg, input logic restart);
    srg_sent = 0; bit_sent = 0; wr_idx = 0;
    cfg_in_i = cfg;
    @(negedge clk);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk("R1 busy", busy_o, 1);
    chk("R1 resets all held", rst_ctl_o, 4'b1111);
    chk("R1 dma off", dma_dis_o, 1);
    chk("R1 cfg prior", cfg_o, cfg);
    chk("R10 err cleared at start", err_o, 0);
    @(negedge clk);
    chk("R2 cfg internal", cfg_o, 7'h3F);
    chk("R2 resets still held", rst_ctl_o, 4'b1111);
    @(negedge clk);
    chk("R3 frame only held", rst_ctl_o, 4'b0100);
    if (restart) begin
      start_i = 1;
      @(negedge clk);
      start_i = 0;
      chk("R11 restart ignored", rst_ctl_o, 4'b0100);
      chk("R11 still busy", busy_o, 1);
    end
  endtask

  task automatic full_seq(input logic [6:0] cfg, input logic rx, input int wake_dly, input logic restart);
    exp_q.push_back(EV_BUSY);
    exp_q.push_back(EV_WR);
    exp_q.push_back(EV_WR);
    if (rx) exp_q.push_back(EV_RD);
    exp_q.push_back(EV_PDN);
    exp_q.push_back(EV_DONE);
    recv_rdy_i = rx;
    xmit_rdy_i = 1;
    begin_seq(cfg, restart);
    cfg_in_i = ~cfg;
    send_srg_ticks(2);
    wait_for(0);
    xmit_rdy_i = 0;
    repeat (3) @(negedge clk);
    bit_tick_i = 1; xmit_rdy_i = 1; bit_sent++;
    @(negedge clk);
    bit_tick_i = 0;
    wait_for(0);
    xmit_rdy_i = 0;
    wait_for(1);
    chk("R3 frame held during request", rst_ctl_o, 4'b0100);
    recv_rdy_i = 0;
    repeat (wake_dly) @(negedge clk);
    chk("R8 request held until wake", pdn_req_o, 1);
    wake_i = 1;
    @(negedge clk);
    wake_i = 0;
    chk("R9 done", done_o, 1);
    chk("R9 cfg restored", cfg_o, cfg);
    chk("R9 resets released", rst_ctl_o, 4'b0000);
    chk("R9 request dropped", pdn_req_o, 0);
    chk("R9 busy low", busy_o, 0);
    chk("R10 no error", err_o, 0);
    @(negedge clk);
    chk("R9 done one cycle", done_o, 0);
  endtask

  task automatic timeout_seq(input logic [6:0] cfg, input logic in_bitwait);
    exp_q.push_back(EV_BUSY);
    if (in_bitwait) exp_q.push_back(EV_WR);
    exp_q.push_back(EV_DONE);
    xmit_rdy_i = 1;
    begin_seq(cfg, 1'b0);
    if (in_bitwait) begin
      send_srg_ticks(2);
      wait_for(0);
      xmit_rdy_i = 0;
    end
    wait_for(2);
    chk("R10 error flag", err_o, 1);
    chk("R10 cfg restored", cfg_o, cfg);
    chk("R10 no request", pdn_req_o, 0);
    repeat (3) @(negedge clk);
    chk("R10 error sticky", err_o, 1);
    chk("R10 idle after timeout", busy_o, 0);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        total++; bad++;
        $display("FAIL watchdog act=%0d exp=done", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R12 reset outputs", {rst_ctl_o, cfg_o, dma_dis_o, tx_wr_o, tx_data_o,
                              rx_rd_o, pdn_req_o, busy_o, done_o, err_o}, 0);
    full_seq(7'h15, 1'b0, 3, 1'b0);
    full_seq(7'h4A, 1'b1, 1, 1'b1);
    timeout_seq(7'h33, 1'b0);
    timeout_seq(7'h0C, 1'b1);
    full_seq(7'h60, 1'b1, 5, 1'b0);
    repeat (4) @(negedge clk);
    chk("R8 no pending events", exp_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule